// File: doc/BRIEF.md
# Serial Port Register Front End

This block sits between a simple byte-wide processor read/write port and an existing serial shift-register core. It decodes an eight-entry address window and gives the processor three things: a transmit holding register to write, a receive buffer to read, and a line status register that shows at any moment whether a received byte is waiting, whether a new transmit byte may be written, and whether a received byte was lost.

Address offset 0 has two meanings. A write there goes to the transmit holding register, and a read there returns the receive buffer. The status bits are set and cleared by events in the core as well as by processor accesses. Reads have side effects: reading the receive byte clears the byte-waiting flag, and reading line status clears the sticky overrun flag. The core is reached through two plain handshakes. The transmit side is a valid/ready pair. On the receive side, a one-cycle valid strobe delivers each byte and the block always accepts it.

Top module: `sio_reg_frontend`

## Requirements
- R1: After reset, line status reads 0x20, a read at offset 0 returns 0x00, and `txValid` is low.
- R2: A write at offset 0 while line status bit 5 is set makes `txValid` high with `txData` equal to the written byte from the next cycle on, and line status bit 5 reads 0 from that cycle.
- R3: A write at offset 0 while line status bit 5 is clear is dropped, and `txData` keeps its previous byte.
- R4: `txValid` and `txData` hold steady until `txReady` is seen high. In the cycle after that handshake, `txValid` is low and line status bit 5 is 1.
- R5: A cycle with `rxValid` high stores `rxData` in the receive buffer. From the next cycle, line status bit 0 is 1 and a read at offset 0 returns that byte.
- R6: A read at offset 0 while bit 0 is set returns the byte and clears bit 0 from the next cycle. A read at offset 0 while bit 0 is clear returns the last stored byte and changes nothing.
- R7: If `rxValid` arrives while bit 0 is set and there is no read at offset 0 in that cycle, the new byte replaces the old one and line status bit 1 (overrun) is 1 from the next cycle.
- R8: A line status read clears bit 1 from the next cycle. If a new overrun happens in the same cycle, bit 1 stays set.
- R9: If `rxValid` arrives in the same cycle as a read at offset 0 that consumes a byte, the read returns the old byte, the new byte is stored, bit 0 stays 1, and no overrun is flagged.
- R10: Offsets 1, 2, 3, 4, 6 and 7 read as 0x00. Writes to them change neither line status nor the transmit handshake.
- R11: `cpuRdata` is 0x00 in any cycle without a read access (`cpuSel` low or `cpuWr` high).
- R12: Line status bits 2, 3, 4, 6 and 7 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuSel | input | 1 | Access strobe, one access per cycle |
| cpuWr | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W (3) | Register offset |
| cpuWdata | input | DATA_W (8) | Write byte |
| cpuRdata | output | DATA_W (8) | Read byte, combinational for the current access |
| txValid | output | 1 | Transmit byte offered to the core |
| txReady | input | 1 | Core takes the offered byte |
| txData | output | DATA_W (8) | Transmit byte |
| rxValid | input | 1 | One-cycle strobe for a received byte |
| rxData | input | DATA_W (8) | Received byte |

## Verification
The assertions assume that an access lasts exactly one cycle, that `cpuWr` and `cpuAddr` are only meaningful while `cpuSel` is high, and that `rxValid` is a single-cycle strobe the block never back-pressures. The bench follows these rules. It changes every input half a cycle away from the active edge and issues at most one access per cycle. Its random phase draws offsets across the whole window and uses free-running `rxValid` and `txReady`, so the corner cases arise naturally: overlapping receive and read, overrun, and status reads that collide with new overruns.

// File: rtl/sio_reg_pkg.sv
package sio_reg_pkg;

  // Line status bit positions; a driver decodes these, so they are fixed.
  localparam int unsigned LSR_READY_BIT   = 0;
  localparam int unsigned LSR_OVERRUN_BIT = 1;
  localparam int unsigned LSR_THRE_BIT    = 5;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadThr;  // capture write byte into transmit holding register
    logic loadRbr;  // capture received byte into receive buffer
    logic selRbr;   // present receive buffer on read data
    logic selLsr;   // present line status on read data
  } sioStrobes_t;

endpackage

// File: rtl/sio_reg_ctrl.sv
module sio_reg_ctrl
  import sio_reg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned DATA_OFS = 0,
  parameter int unsigned STAT_OFS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuSel,
  input  logic              cpuWr,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              txReady,
  input  logic              rxValid,
  output sioStrobes_t       strobes,
  output logic              thrEmpty,
  output logic              dataReady,
  output logic              overrun
);

  localparam logic [ADDR_W-1:0] DataAddr = ADDR_W'(DATA_OFS);
  localparam logic [ADDR_W-1:0] StatAddr = ADDR_W'(STAT_OFS);

  logic rdData, wrData, rdStat;
  logic consume, txFire, overrunEvent;

  always_comb begin
    rdData       = cpuSel && !cpuWr && (cpuAddr == DataAddr);
    wrData       = cpuSel &&  cpuWr && (cpuAddr == DataAddr);
    rdStat       = cpuSel && !cpuWr && (cpuAddr == StatAddr);
    consume      = rdData && dataReady;
    txFire       = !thrEmpty && txReady;
    overrunEvent = rxValid && dataReady && !consume;

    strobes.loadThr = wrData && thrEmpty;
    strobes.loadRbr = rxValid;
    strobes.selRbr  = rdData;
    strobes.selLsr  = rdStat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thrEmpty  <= 1'b1;
      dataReady <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (strobes.loadThr)  thrEmpty <= 1'b0;
      else if (txFire)      thrEmpty <= 1'b1;

      if (rxValid)          dataReady <= 1'b1;
      else if (consume)     dataReady <= 1'b0;

      if (overrunEvent)     overrun <= 1'b1;
      else if (rdStat)      overrun <= 1'b0;
    end
  end

  assert_thre_after_accept_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!thrEmpty && txReady) |=> thrEmpty);

  assert_read_clears_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdData && dataReady && !rxValid) |=> !dataReady);

  assert_overrun_sets_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && dataReady && !rdData) |=> overrun);

  assert_stat_read_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdStat && !(rxValid && dataReady && !rdData)) |=> !overrun);

  assert_overlap_no_overrun_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdData && dataReady && rxValid && !overrun && !rdStat) |=> (dataReady && !overrun));

endmodule

// File: rtl/sio_reg_datapath.sv
module sio_reg_datapath
  import sio_reg_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sioStrobes_t       strobes,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] rxData,
  input  logic              thrEmpty,
  input  logic              dataReady,
  input  logic              overrun,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [DATA_W-1:0] txData
);

  logic [DATA_W-1:0] thrReg, rbrReg, lsrWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thrReg <= '0;
      rbrReg <= '0;
    end else begin
      if (strobes.loadThr) thrReg <= cpuWdata;
      if (strobes.loadRbr) rbrReg <= rxData;
    end
  end

  always_comb begin
    lsrWord                  = '0;
    lsrWord[LSR_READY_BIT]   = dataReady;
    lsrWord[LSR_OVERRUN_BIT] = overrun;
    lsrWord[LSR_THRE_BIT]    = thrEmpty;

    if (strobes.selRbr)      cpuRdata = rbrReg;
    else if (strobes.selLsr) cpuRdata = lsrWord;
    else                     cpuRdata = '0;
  end

  assign txData = thrReg;

  assert_held_byte_kept_R3: assert property (@(posedge clk) disable iff (!rstN)
    !thrEmpty |=> $stable(txData));

  assert_rx_captured_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadRbr |=> (rbrReg == $past(rxData)));

endmodule

// File: rtl/sio_reg_frontend.sv
module sio_reg_frontend
  import sio_reg_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned DATA_OFS = 0,
  parameter int unsigned STAT_OFS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuSel,
  input  logic              cpuWr,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              txValid,
  input  logic              txReady,
  output logic [DATA_W-1:0] txData,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData
);

  sioStrobes_t strobes;
  logic thrEmpty, dataReady, overrun;

  sio_reg_ctrl #(.ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .STAT_OFS(STAT_OFS)) uCtrl (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuAddr(cpuAddr),
    .txReady(txReady), .rxValid(rxValid), .strobes(strobes),
    .thrEmpty(thrEmpty), .dataReady(dataReady), .overrun(overrun)
  );

  sio_reg_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cpuWdata(cpuWdata), .rxData(rxData),
    .thrEmpty(thrEmpty), .dataReady(dataReady), .overrun(overrun),
    .cpuRdata(cpuRdata), .txData(txData)
  );

  assign txValid = !thrEmpty;

  logic dataWrite, otherAccess;
  assign dataWrite   = cpuSel && cpuWr && (cpuAddr == ADDR_W'(DATA_OFS));
  assign otherAccess = cpuSel && (cpuAddr != ADDR_W'(DATA_OFS)) && (cpuAddr != ADDR_W'(STAT_OFS));

  assert_write_hands_over_R2: assert property (@(posedge clk) disable iff (!rstN)
    (dataWrite && !txValid) |=> (txValid && txData == $past(cpuWdata)));

  assert_tx_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData)));

  assert_unused_read_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (otherAccess && !cpuWr) |-> (cpuRdata == '0));

  assert_idle_read_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuSel || cpuWr) |-> (cpuRdata == '0));

endmodule

// File: tb/tb_sio_reg_frontend.sv
`timescale 1ns/1ps
module tb_sio_reg_frontend;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpuSel = 1'b0, cpuWr = 1'b0;
  logic [2:0] cpuAddr = '0;
  logic [7:0] cpuWdata = '0, rxData = '0;
  logic       txReady = 1'b0, rxValid = 1'b0;
  logic [7:0] cpuRdata, txData;
  logic       txValid;

  always #2.5 clk = ~clk;

  sio_reg_frontend dut (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .txValid(txValid), .txReady(txReady),
    .txData(txData), .rxValid(rxValid), .rxData(rxData)
  );

  int errors = 0, checks = 0;
  string tag = "R1";

  // Behavioural reference state
  bit     mEmpty = 1, mReady = 0, mOver = 0;
  integer mThr = 0, mRbr = 0;

  task automatic chk(string req, string what, integer act, integer exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic integer expRead();
    if (!cpuSel || cpuWr) return 0;
    if (cpuAddr == 0) return mRbr;
    if (cpuAddr == 5) return (mEmpty ? 32 : 0) + (mOver ? 2 : 0) + (mReady ? 1 : 0);
    return 0;
  endfunction

  // Compare before the edge, advance model at the edge, return at the falling edge.
  task automatic cyc();
    bit rd0, wr0, rdS, take;
    #1;
    chk(tag, "rdata", cpuRdata, expRead());
    chk(tag, "txValid", txValid, !mEmpty);
    if (!mEmpty) chk(tag, "txData", txData, mThr);
    rd0 = cpuSel && !cpuWr && cpuAddr == 0;
    wr0 = cpuSel && cpuWr && cpuAddr == 0;
    rdS = cpuSel && !cpuWr && cpuAddr == 5;
    take = rd0 && mReady;
    @(posedge clk);
    if (!mEmpty && txReady) mEmpty = 1;
    else if (wr0 && mEmpty) begin mThr = cpuWdata; mEmpty = 0; end
    if (rxValid && mReady && !take) mOver = 1;
    else if (rdS) mOver = 0;
    if (rxValid) begin mRbr = rxData; mReady = 1; end
    else if (take) mReady = 0;
    @(negedge clk);
  endtask

  task automatic idle();
    cpuSel = 0; cpuWr = 0; rxValid = 0; txReady = 0;
  endtask

  task automatic acc(bit wr, int addr, int data);
    cpuSel = 1; cpuWr = wr; cpuAddr = 3'(addr); cpuWdata = 8'(data);
  endtask

  initial begin : watchdog
    #600us;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1;
    // R1 reset state
    tag = "R1"; acc(0, 5, 0); #1; chk("R1", "lsr", cpuRdata, 8'h20); cyc();
    acc(0, 0, 0); cyc();
    // R11 no access
    tag = "R11"; idle(); cyc(); acc(1, 5, 8'hFF); cyc();
    // R2 write handover
    tag = "R2"; acc(1, 0, 8'hA5); cyc(); idle();
    chk("R2", "txData", txData, 8'hA5);
    acc(0, 5, 0); #1; chk("R2", "lsr bit5", cpuRdata[5], 0); cyc();
    // R3 dropped write
    tag = "R3"; acc(1, 0, 8'h3C); cyc(); idle(); chk("R3", "txData", txData, 8'hA5); cyc();
    // R4 hold then release
    tag = "R4"; repeat (3) cyc(); txReady = 1; cyc(); txReady = 0;
    chk("R4", "txValid", txValid, 0);
    acc(0, 5, 0); #1; chk("R4", "lsr bit5", cpuRdata[5], 1); cyc(); idle();
    // R5 receive
    tag = "R5"; rxValid = 1; rxData = 8'h5A; cyc(); rxValid = 0;
    acc(0, 5, 0); #1; chk("R5", "lsr bit0", cpuRdata[0], 1); cyc();
    // R6 consume
    tag = "R6"; acc(0, 0, 0); #1; chk("R6", "rbr", cpuRdata, 8'h5A); cyc();
    acc(0, 5, 0); #1; chk("R6", "lsr bit0", cpuRdata[0], 0); cyc();
    acc(0, 0, 0); #1; chk("R6", "stale rbr", cpuRdata, 8'h5A); cyc(); idle();
    // R7 overrun
    tag = "R7"; rxValid = 1; rxData = 8'h11; cyc(); rxData = 8'h22; cyc(); rxValid = 0;
    acc(0, 0, 0); #1; chk("R7", "rbr replaced", cpuRdata, 8'h22); cyc();
    // R8 status read clears overrun
    tag = "R8"; acc(0, 5, 0); #1; chk("R8", "lsr", cpuRdata, 8'h22); cyc();
    #1; chk("R8", "lsr cleared", cpuRdata, 8'h20); cyc(); idle();
    rxValid = 1; rxData = 8'h33; cyc();
    rxData = 8'h44; acc(0, 5, 0); cyc(); rxValid = 0;
    #1; chk("R8", "lsr overrun kept", cpuRdata[1], 1); cyc(); idle();
    acc(0, 0, 0); cyc(); idle();
    // R9 overlap of read and receive
    tag = "R9"; rxValid = 1; rxData = 8'h55; cyc();
    rxData = 8'h66; acc(0, 0, 0); #1; chk("R9", "old byte", cpuRdata, 8'h55); cyc();
    rxValid = 0; acc(0, 5, 0); #1; chk("R9", "lsr", cpuRdata, 8'h21); cyc();
    acc(0, 0, 0); #1; chk("R9", "new byte", cpuRdata, 8'h66); cyc(); idle();
    // R10 unused offsets, R12 reserved status bits
    tag = "R10";
    for (int a = 1; a < 8; a++) begin
      if (a == 5) continue;
      acc(1, a, 8'hC3); cyc(); acc(0, a, 0); #1; chk("R10", "unused read", cpuRdata, 0); cyc();
    end
    idle(); chk("R10", "txValid", txValid, 0);
    acc(0, 5, 0); #1; chk("R10", "lsr", cpuRdata, 8'h20); cyc();
    // Mixed random traffic
    tag = "R12";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 3);
      cpuSel = (r != 0); cpuWr = $urandom_range(0, 1);
      cpuAddr = ($urandom_range(0, 1) != 0) ? 3'(5 * $urandom_range(0, 1)) : 3'($urandom_range(0, 7));
      cpuWdata = 8'($urandom); rxData = 8'($urandom);
      rxValid = ($urandom_range(0, 3) == 0); txReady = ($urandom_range(0, 2) == 0);
      if (cpuSel && !cpuWr && cpuAddr == 5) begin
        #1; chk("R12", "reserved bits", cpuRdata & 8'hDC, 0);
      end
      cyc();
    end
    idle(); cyc();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule